// File: doc/BRIEF.md
# Strobe-Clocked Bus Write Capture

This block moves write cycles from an asynchronous processor bus into a local clock domain. The processor's write strobe serves as the capture clock. On its rising edge, the address and data on the bus are latched into capture registers, and a toggle flag inverts.

The flag crosses into the local domain through a flip-flop synchronizer. A compare against its previously seen value turns every change of the flag into a one-cycle transfer enable. That enable copies the held address and data into locally clocked output registers and raises a one-cycle valid.

The scheme expects writes to be spaced at least three local clock periods apart. If a second change of the flag is detected in the cycle right after a transfer, a sticky overrun flag is set. Only the local reset clears it.

Top module: `strobe_write_capture`

## Requirements
- R1: The address and data that reach the outputs are the values present on the bus at the rising edge of the write strobe; bus changes after that edge do not alter the transferred word.
- R2: Each rising edge of the write strobe, with edges at least three local periods apart, produces exactly one `out_valid` pulse carrying that write's address and data.
- R3: When a strobe rising edge falls 1 ns after a local rising edge, `out_valid` is low after the second following local rising edge and high after the third.
- R4: `out_valid` is one local cycle wide unless `overrun` is set. `out_addr` and `out_data` change only on the edge that raises `out_valid`.
- R5: Back-to-back writes transfer correctly for both polarities of the toggle flag, rising (0 to 1) and falling (1 to 0).
- R6: If a flag change is detected in the cycle that immediately follows a transfer, `overrun` goes high. It stays high through later writes until `rst` is asserted.
- R7: While `rst` is high and after it is released with the strobe idle, `out_valid`, `overrun`, `out_addr` and `out_data` are all 0, and no transfer occurs.
- R8: Bus address and data changes with no strobe edge have no effect on any output.
- R9: With writes spaced at least three local periods apart, `overrun` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Local clock |
| rst | input | 1 | Active-high reset; synchronous for local logic, asynchronous for the strobe-side flag |
| wr_strobe | input | 1 | Processor write strobe; its rising edge captures a write |
| bus_addr | input | ADDR_W | Processor address |
| bus_data | input | DATA_W | Processor write data |
| out_addr | output | ADDR_W | Transferred address, local domain |
| out_data | output | DATA_W | Transferred data, local domain |
| out_valid | output | 1 | One-cycle pulse when a new write is published |
| overrun | output | 1 | Sticky flag: writes arrived faster than the transfer path allows |

## Verification
The bench builds the block with its defaults: an 8-bit address, 16-bit data and a two-stage synchronizer. Under these values the latency from strobe to valid is exactly three local edges, which lets the bench check the cycle boundary of R3 directly.

Strobes are placed relative to the 200 MHz local clock. Placing two strobes one local period apart forces the overrun path and the double valid it produces. A 16-bit data width lets the bench use wide alternating patterns for both flag polarities.

// File: rtl/swc_pkg.sv
package swc_pkg;
  typedef enum logic [0:0] {
    ST_IDLE    = 1'b0,
    ST_PUBLISH = 1'b1
  } xfer_state_t;
endpackage

// File: rtl/swc_capture.sv
module swc_capture #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 16
) (
  input  logic              wr_strobe,
  input  logic              rst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_data,
  output logic [ADDR_W-1:0] cap_addr,
  output logic [DATA_W-1:0] cap_data,
  output logic              wr_flag
);
  // Strobe domain: the strobe is the clock. The flag must be reset without
  // strobe edges, so it alone takes the reset asynchronously.
  always_ff @(posedge wr_strobe or posedge rst) begin
    if (rst) wr_flag <= 1'b0;
    else     wr_flag <= ~wr_flag;
  end

  always_ff @(posedge wr_strobe) begin
    cap_addr <= bus_addr;
    cap_data <= bus_data;
  end
endmodule

// File: rtl/swc_sync.sv
module swc_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic async_in,
  output logic sync_out
);
  logic [STAGES-1:0] stg;

  always_ff @(posedge clk) begin
    if (rst) stg[0] <= 1'b0;
    else     stg[0] <= async_in;
  end

  for (genvar i = 1; i < STAGES; i++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst) stg[i] <= 1'b0;
      else     stg[i] <= stg[i-1];
    end
  end

  assign sync_out = stg[STAGES-1];

  // R3: the output only ever takes the value the stage before it held
  a_r3_sync_path: assert property (@(posedge clk) disable iff (rst)
    !$stable(sync_out) |-> (sync_out == $past(stg[STAGES-2])));
endmodule

// File: rtl/swc_edge_fsm.sv
module swc_edge_fsm
  import swc_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic flag_sync,
  output logic xfer_en,
  output logic overrun
);
  logic        flag_seen;
  xfer_state_t state;

  assign xfer_en = flag_sync ^ flag_seen;

  always_ff @(posedge clk) begin
    if (rst) begin
      flag_seen <= 1'b0;
      state     <= ST_IDLE;
      overrun   <= 1'b0;
    end else begin
      flag_seen <= flag_sync;
      state     <= xfer_en ? ST_PUBLISH : ST_IDLE;
      if (xfer_en && state == ST_PUBLISH) overrun <= 1'b1;
    end
  end

  // R6: once set, overrun holds until reset
  a_r6_sticky: assert property (@(posedge clk) disable iff (rst)
    overrun |=> overrun);
  // R6: overrun only rises after a transfer in the previous cycle
  a_r6_cause: assert property (@(posedge clk) disable iff (rst)
    $rose(overrun) |-> $past(xfer_en));
endmodule

// File: rtl/strobe_write_capture.sv
module strobe_write_capture #(
  parameter int ADDR_W      = 8,
  parameter int DATA_W      = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_strobe,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_data,
  output logic [ADDR_W-1:0] out_addr,
  output logic [DATA_W-1:0] out_data,
  output logic              out_valid,
  output logic              overrun
);
  logic [ADDR_W-1:0] cap_addr;
  logic [DATA_W-1:0] cap_data;
  logic              wr_flag;
  logic              flag_sync;
  logic              xfer_en;

  swc_capture #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_cap (
    .wr_strobe (wr_strobe),
    .rst       (rst),
    .bus_addr  (bus_addr),
    .bus_data  (bus_data),
    .cap_addr  (cap_addr),
    .cap_data  (cap_data),
    .wr_flag   (wr_flag)
  );

  swc_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk      (clk),
    .rst      (rst),
    .async_in (wr_flag),
    .sync_out (flag_sync)
  );

  swc_edge_fsm u_fsm (
    .clk       (clk),
    .rst       (rst),
    .flag_sync (flag_sync),
    .xfer_en   (xfer_en),
    .overrun   (overrun)
  );

  // Transfer registers: the enable is their only load condition.
  always_ff @(posedge clk) begin
    if (rst) begin
      out_addr  <= '0;
      out_data  <= '0;
      out_valid <= 1'b0;
    end else begin
      out_valid <= xfer_en;
      if (xfer_en) begin
        out_addr <= cap_addr;
        out_data <= cap_data;
      end
    end
  end

  // R4: valid is a single cycle unless overrun was raised
  a_r4_valid_width: assert property (@(posedge clk) disable iff (rst)
    out_valid |=> (!out_valid || overrun));
  // R4: outputs hold when no transfer is enabled
  a_r4_hold: assert property (@(posedge clk) disable iff (rst)
    !xfer_en |=> ($stable(out_addr) && $stable(out_data)));
endmodule

// File: tb/strobe_write_capture_tb.sv
`timescale 1ns/100ps
module strobe_write_capture_tb;
  localparam int AW = 8;
  localparam int DW = 16;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          wr_strobe = 1'b0;
  logic [AW-1:0] bus_addr = '0;
  logic [DW-1:0] bus_data = '0;
  logic [AW-1:0] out_addr;
  logic [DW-1:0] out_data;
  logic          out_valid;
  logic          overrun;

  int errors = 0;
  int checks = 0;
  logic [AW+DW-1:0] sb_q[$];

  always #2.5 clk = ~clk;

  strobe_write_capture #(.ADDR_W(AW), .DATA_W(DW)) u_dut (
    .clk(clk), .rst(rst), .wr_strobe(wr_strobe),
    .bus_addr(bus_addr), .bus_data(bus_data),
    .out_addr(out_addr), .out_data(out_data),
    .out_valid(out_valid), .overrun(overrun)
  );

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Scoreboard monitor (R1, R2, R5)
  always @(negedge clk) begin
    if (!rst && out_valid) begin
      if (sb_q.size() == 0) begin
        check(1'b0, "R2 unexpected valid", {8'h0, out_addr, out_data}, 32'h0);
      end else begin
        logic [AW+DW-1:0] e;
        e = sb_q.pop_front();
        check({out_addr, out_data} == e, "R1/R2/R5 transferred word", {8'h0, out_addr, out_data}, {8'h0, e});
      end
    end
  end

  // Strobe pulse 1 ns after a local edge; bus scrambled after the edge (R1)
  task automatic strobe_pulse(input logic [AW-1:0] a, input logic [DW-1:0] d);
    @(posedge clk);
    bus_addr = a; bus_data = d;
    #1 wr_strobe = 1'b1;
    #0.5 bus_addr = ~a; bus_data = ~d;
    #1 wr_strobe = 1'b0;
  endtask

  task automatic do_write(input logic [AW-1:0] a, input logic [DW-1:0] d, input int gap);
    sb_q.push_back({a, d});
    strobe_pulse(a, d);
    repeat (gap) @(posedge clk);
  endtask

  initial begin : watchdog
    #500000;
    errors++; checks++;
    $display("FAIL watchdog actual=1 expected=0");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin : main
    repeat (4) @(posedge clk);
    @(negedge clk);
    check(!out_valid && !overrun && out_addr == 0 && out_data == 0, "R7 in reset", {out_valid, overrun}, 0);
    rst = 1'b0;
    repeat (6) @(negedge clk);
    check(!out_valid && out_addr == 0 && out_data == 0, "R7 no spurious transfer", {out_valid, out_addr}, 0);

    // R3 latency
    sb_q.push_back({8'h5A, 16'hC3A5});
    strobe_pulse(8'h5A, 16'hC3A5);
    @(negedge clk);                       // after k1 (n1)
    @(negedge clk);                       // after k2
    check(!out_valid, "R3 not yet valid", out_valid, 0);
    @(negedge clk);                       // after k3
    check(out_valid, "R3 valid on third edge", out_valid, 1);
    @(negedge clk);
    check(!out_valid, "R4 single-cycle valid", out_valid, 0);
    check(out_addr == 8'h5A && out_data == 16'hC3A5, "R4 outputs hold", {out_addr, out_data}, {8'h5A, 16'hC3A5});

    // R8 bus activity without strobe
    bus_addr = 8'hFF; bus_data = 16'h1234;
    repeat (8) @(negedge clk);
    check(out_addr == 8'h5A && out_data == 16'hC3A5 && !out_valid, "R8 no effect", {out_addr, out_data}, {8'h5A, 16'hC3A5});

    // R5, R9: back-to-back writes at minimum spacing, both flag polarities
    for (int i = 0; i < 16; i++) begin
      do_write(AW'(i * 37 + 1), (i % 2) ? 16'hAAAA ^ DW'(i) : 16'h5555 ^ DW'(i * 11), 2);
    end
    repeat (8) @(negedge clk);
    check(sb_q.size() == 0, "R2 every write delivered", sb_q.size(), 0);
    check(!overrun, "R9 no overrun at legal spacing", overrun, 0);

    // R6 overrun: two strobes one local period apart; both copies see the second word
    sb_q.push_back({8'h77, 16'hBEEF});
    sb_q.push_back({8'h77, 16'hBEEF});
    strobe_pulse(8'h11, 16'h2222);
    strobe_pulse(8'h77, 16'hBEEF);
    repeat (8) @(negedge clk);
    check(overrun, "R6 overrun set", overrun, 1);
    check(sb_q.size() == 0, "R6 both transfers seen", sb_q.size(), 0);
    do_write(8'h42, 16'h0F0F, 6);
    @(negedge clk);
    check(overrun, "R6 overrun sticky", overrun, 1);

    // R7 reset clears
    @(posedge clk); rst = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(!overrun && !out_valid && out_addr == 0 && out_data == 0, "R7 reset clears", {overrun, out_valid}, 0);
    rst = 1'b0;
    repeat (6) @(negedge clk);
    check(!out_valid && !overrun, "R7 quiet after reset", {overrun, out_valid}, 0);
    do_write(8'hC9, 16'h8001, 6);
    @(negedge clk);
    check(sb_q.size() == 0 && out_addr == 8'hC9 && out_data == 16'h8001, "R2 write after reset", {out_addr, out_data}, {8'hC9, 16'h8001});

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule